// File: doc/BRIEF.md
# MAC Interrupt Status Aggregator

This block holds the interrupt status and interrupt enable registers of an Ethernet MAC and turns them into two interrupt lines, one for the transmit side and one for the receive side. The transmit and receive engines report events as single-cycle set pulses on a 32-bit vector. Each pulse sets a status bit, and that bit stays set until software clears it. The upper half of the status word belongs to the transmit side and the lower half to the receive side. The lowest bit of each half is a summary bit. The block computes it from a chosen subset of that half's cause bits, each gated by its own enable bit.

Software reaches the registers over a simple 32-bit bus. It writes the enable register directly and clears status bits by writing ones to them. Each interrupt line is the summary bit of its half ANDed with the enable bit at the summary position, and it is registered. A soft reset input clears everything in a single cycle.

Top module: `mis_aggregator`

## Requirements
- R1: After the synchronous reset, the status register, the enable register, `bus_rdata`, `irq_tx` and `irq_rx` are all zero.
- R2: A pulse on `evt_set[i]` sets status bit i, where i is any position other than 0 and 16. The bit stays set after the pulse ends.
- R3: A bus write to the status register (`bus_addr`=0) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R4: When a set pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: Status bit 16 is the transmit summary. In the same clock edge that updates the status register, it becomes 1 if any of bits 17 (transmit done), 18 (no transmit descriptor) or 19 (transmit bus error) is set together with the enable bit at the same position. Otherwise it becomes 0. Other transmit-half bits, such as bit 20, have no effect on it.
- R6: Status bit 0 is the receive summary, formed the same way from bits 1 (receive good), 2 (no receive descriptor) and 3 (receive bus error). Bit 4 and above have no effect on it.
- R7: Set pulses on bits 0 and 16 are ignored. A write of 1 to a summary bit leaves it set while any enabled cause in its half is still set.
- R8: A write to the enable register (`bus_addr`=1) recomputes both summary bits in the same edge as the enable update.
- R9: `irq_tx` equals status bit 16 AND enable bit 16, and `irq_rx` equals status bit 0 AND enable bit 0. Each line changes exactly one cycle after the status or enable change that causes it.
- R10: A pulse on `soft_rst` clears status, enable, `irq_tx` and `irq_rx` at the next edge. It takes priority over set pulses in the same cycle.
- R11: `bus_rdata` presents the status register when `bus_addr`=0 and the enable register when `bus_addr`=1, one cycle after the address is applied. The enable register stores all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Single-cycle soft reset of both registers and both lines |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | Register select: 0 status, 1 enable |
| bus_wdata | input | 32 | Write data (ones-to-clear for status) |
| bus_rdata | output | 32 | Registered read data |
| evt_set | input | 32 | Event set pulses, transmit in 31:16, receive in 15:0 |
| irq_tx | output | 1 | Transmit interrupt line |
| irq_rx | output | 1 | Receive interrupt line |

## Verification
The hardest situation to reach is a set pulse and a clearing write that land on the same status bit in the same cycle. The bench produces it by driving `evt_set` and a status write at the same falling edge, then reading the bit back. A second case is a summary that changes only because of an enable write while the cause bits stay still. The stimulus latches causes with their enables off, then enables them, and observes both the status readback and the one-cycle lag of the interrupt lines.

// File: rtl/mis_pkg.sv
package mis_pkg;
  localparam int HALF_W_DEF = 16;
  // Bit positions inside one half of the status word.
  localparam int SUM_POS    = 0;
  localparam int DONE_POS   = 1;
  localparam int NODESC_POS = 2;
  localparam int BUSERR_POS = 3;
  localparam logic [HALF_W_DEF-1:0] CAUSE_DEF =
    HALF_W_DEF'((1 << DONE_POS) | (1 << NODESC_POS) | (1 << BUSERR_POS));
  typedef enum logic {SEL_STATUS = 1'b0, SEL_ENABLE = 1'b1} reg_sel_e;
endpackage

// File: rtl/mis_enable_reg.sv
module mis_enable_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_clr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] en_q,
  output logic [DATA_W-1:0] en_nxt
);
  always_comb begin
    if (soft_clr)   en_nxt = '0;
    else if (wr_en) en_nxt = wdata;
    else            en_nxt = en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_nxt;
  end

  a_r8_enable_hold: assert property (@(posedge clk) disable iff (rst)
    (!soft_clr && !wr_en) |=> $stable(en_q));
endmodule

// File: rtl/mis_evt_half.sv
module mis_evt_half #(
  parameter int                HALF_W     = 16,
  parameter int                SUM_IDX    = 0,
  parameter logic [HALF_W-1:0] CAUSE_MASK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_clr,
  input  logic [HALF_W-1:0] set_pulse,
  input  logic [HALF_W-1:0] clr_mask,
  input  logic [HALF_W-1:0] en_nxt,
  output logic [HALF_W-1:0] stat_q
);
  localparam logic [HALF_W-1:0] SUM_MSK   = {{(HALF_W-1){1'b0}}, 1'b1} << SUM_IDX;
  localparam logic [HALF_W-1:0] PLAIN_MSK = ~SUM_MSK;
  localparam logic [HALF_W-1:0] EFF_CAUSE = CAUSE_MASK & PLAIN_MSK;

  logic [HALF_W-1:0] plain_nxt;
  logic              sum_nxt;

  // Set dominates clear; summary follows the values being stored.
  always_comb begin
    plain_nxt = ((stat_q & ~clr_mask) | set_pulse) & PLAIN_MSK;
    sum_nxt   = |(plain_nxt & en_nxt & EFF_CAUSE);
  end

  always_ff @(posedge clk) begin
    if (rst || soft_clr) stat_q <= '0;
    else                 stat_q <= plain_nxt | (sum_nxt ? SUM_MSK : '0);
  end

  a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
    !soft_clr |=> ((stat_q & $past(set_pulse & PLAIN_MSK)) == $past(set_pulse & PLAIN_MSK)));

  a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
    !soft_clr |=> ((stat_q & $past(stat_q & ~clr_mask & PLAIN_MSK))
                   == $past(stat_q & ~clr_mask & PLAIN_MSK)));

  a_r3_clear_only_by_write: assert property (@(posedge clk) disable iff (rst)
    !soft_clr |=> ((stat_q & PLAIN_MSK & ~$past(stat_q) & ~$past(set_pulse)) == '0));
endmodule

// File: rtl/mis_irq_out.sv
module mis_irq_out (
  input  logic clk,
  input  logic rst,
  input  logic soft_clr,
  input  logic sum_in,
  input  logic en_bit,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (rst || soft_clr) irq_q <= 1'b0;
    else                 irq_q <= sum_in & en_bit;
  end

  a_r9_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(sum_in && en_bit));

  a_r9_fall_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_q) |-> $past(!sum_in || !en_bit || soft_clr));
endmodule

// File: rtl/mis_aggregator.sv
module mis_aggregator #(
  parameter int                  HALF_W   = mis_pkg::HALF_W_DEF,
  parameter int                  SUM_IDX  = mis_pkg::SUM_POS,
  parameter logic [HALF_W-1:0]   TX_CAUSE = mis_pkg::CAUSE_DEF,
  parameter logic [HALF_W-1:0]   RX_CAUSE = mis_pkg::CAUSE_DEF,
  localparam int                 DATA_W   = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] evt_set,
  output logic              irq_tx,
  output logic              irq_rx
);
  import mis_pkg::*;

  logic [DATA_W-1:0] en_q, en_nxt, stat_all, clr_vec;
  logic              en_wr;
  logic [1:0]        irq_vec;

  assign en_wr   = bus_wr && (bus_addr == SEL_ENABLE);
  assign clr_vec = (bus_wr && (bus_addr == SEL_STATUS)) ? bus_wdata : '0;

  mis_enable_reg #(.DATA_W(DATA_W)) u_en (
    .clk(clk), .rst(rst), .soft_clr(soft_rst), .wr_en(en_wr),
    .wdata(bus_wdata), .en_q(en_q), .en_nxt(en_nxt));

  // Half 0 is receive, half 1 is transmit.
  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam logic [HALF_W-1:0] CM = (h == 1) ? TX_CAUSE : RX_CAUSE;
    mis_evt_half #(.HALF_W(HALF_W), .SUM_IDX(SUM_IDX), .CAUSE_MASK(CM)) u_half (
      .clk(clk), .rst(rst), .soft_clr(soft_rst),
      .set_pulse(evt_set[h*HALF_W +: HALF_W]),
      .clr_mask(clr_vec[h*HALF_W +: HALF_W]),
      .en_nxt(en_nxt[h*HALF_W +: HALF_W]),
      .stat_q(stat_all[h*HALF_W +: HALF_W]));
    mis_irq_out u_irq (
      .clk(clk), .rst(rst), .soft_clr(soft_rst),
      .sum_in(stat_all[h*HALF_W + SUM_IDX]),
      .en_bit(en_q[h*HALF_W + SUM_IDX]),
      .irq_q(irq_vec[h]));
  end

  assign irq_rx = irq_vec[0];
  assign irq_tx = irq_vec[1];

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= (bus_addr == SEL_ENABLE) ? en_q : stat_all;
  end

  a_r5_tx_summary: assert property (@(posedge clk) disable iff (rst)
    stat_all[HALF_W + SUM_IDX] == |(stat_all[DATA_W-1:HALF_W] & en_q[DATA_W-1:HALF_W] & TX_CAUSE
                                    & ~(HALF_W'(1) << SUM_IDX)));

  a_r6_rx_summary: assert property (@(posedge clk) disable iff (rst)
    stat_all[SUM_IDX] == |(stat_all[HALF_W-1:0] & en_q[HALF_W-1:0] & RX_CAUSE
                           & ~(HALF_W'(1) << SUM_IDX)));

  a_r10_soft_clears: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (stat_all == '0 && en_q == '0 && !irq_tx && !irq_rx));

  a_r9_irq_lag: assert property (@(posedge clk) disable iff (rst)
    !soft_rst |=> (irq_tx == $past(stat_all[HALF_W + SUM_IDX] && en_q[HALF_W + SUM_IDX])));
endmodule

// File: tb/sim_mis_aggregator.sv
module sim_mis_aggregator;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        soft_rst = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_addr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] evt_set = '0;
  logic        irq_tx, irq_rx;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  mis_aggregator u0 (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_set(evt_set), .irq_tx(irq_tx), .irq_rx(irq_rx));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(logic [31:0] v);
    @(negedge clk) evt_set = v;
    @(negedge clk) evt_set = '0;
  endtask

  task automatic wr(logic a, logic [31:0] d);
    @(negedge clk) begin bus_wr = 1'b1; bus_addr = a; bus_wdata = d; end
    @(negedge clk) begin bus_wr = 1'b0; bus_wdata = '0; end
  endtask

  task automatic rd(logic a, output logic [31:0] d);
    @(negedge clk) bus_addr = a;
    @(negedge clk) d = bus_rdata;
  endtask

  task automatic clear_all();
    wr(1'b1, 32'h0);
    wr(1'b0, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 rdata", bus_rdata, 32'h0);
    check("R1 irq_tx", {31'h0, irq_tx}, 32'h0);
    check("R1 irq_rx", {31'h0, irq_rx}, 32'h0);
    rd(1'b0, d); check("R1 status", d, 32'h0);
    rd(1'b1, d); check("R1 enable", d, 32'h0);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    clear_all();
    pulse(32'h0010_0020);
    rd(1'b0, d); check("R2 sticky", d, 32'h0010_0020);
    repeat (5) @(negedge clk);
    rd(1'b0, d); check("R2 held", d, 32'h0010_0020);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(1'b0, 32'h0000_0020);
    rd(1'b0, d); check("R3 one clears", d, 32'h0010_0000);
    wr(1'b0, 32'h0);
    rd(1'b0, d); check("R3 zero keeps", d, 32'h0010_0000);
    wr(1'b0, 32'h0010_0000);
    rd(1'b0, d); check("R3 clear tx", d, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    clear_all();
    @(negedge clk) begin
      evt_set = 32'h0000_0040; bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = 32'h0000_0040;
    end
    @(negedge clk) begin evt_set = '0; bus_wr = 1'b0; bus_wdata = '0; end
    rd(1'b0, d); check("R4 set wins", d, 32'h0000_0040);
  endtask

  task automatic t_tx_summary();
    logic [31:0] d;
    clear_all();
    wr(1'b1, 32'h0004_0000);
    pulse(32'h0012_0000);
    rd(1'b0, d); check("R5 disabled cause and plain bit", d, 32'h0012_0000);
    pulse(32'h0004_0000);
    rd(1'b0, d); check("R5 tx summary set", d, 32'h0017_0000);
    check("R9 irq_tx needs summary enable", {31'h0, irq_tx}, 32'h0);
  endtask

  task automatic t_rx_summary();
    logic [31:0] d;
    clear_all();
    wr(1'b1, 32'h0000_0003);
    pulse(32'h0000_0010);
    rd(1'b0, d); check("R6 bit4 not cause", d, 32'h0000_0010);
    pulse(32'h0000_0002);
    check("R9 irq_rx lags status", {31'h0, irq_rx}, 32'h0);
    @(negedge clk);
    check("R9 irq_rx rises", {31'h0, irq_rx}, 32'h1);
    rd(1'b0, d); check("R6 rx summary set", d, 32'h0000_0013);
    wr(1'b0, 32'h0000_0002);
    check("R9 irq_rx held one cycle", {31'h0, irq_rx}, 32'h1);
    @(negedge clk);
    check("R9 irq_rx falls", {31'h0, irq_rx}, 32'h0);
    rd(1'b0, d); check("R3 cause clear drops summary", d, 32'h0000_0010);
  endtask

  task automatic t_summary_self();
    logic [31:0] d;
    clear_all();
    pulse(32'h0001_0001);
    rd(1'b0, d); check("R7 summary pulse ignored", d, 32'h0);
    wr(1'b1, 32'h0000_0003);
    pulse(32'h0000_0002);
    wr(1'b0, 32'h0000_0001);
    rd(1'b0, d); check("R7 summary recomputed", d, 32'h0000_0003);
  endtask

  task automatic t_enable_recompute();
    logic [31:0] d;
    clear_all();
    pulse(32'h0008_0008);
    rd(1'b0, d); check("R8 no summary while disabled", d, 32'h0008_0008);
    wr(1'b1, 32'h0009_0009);
    rd(1'b0, d); check("R8 enable raises summaries", d, 32'h0009_0009);
    check("R9 irq_tx high", {31'h0, irq_tx}, 32'h1);
    check("R9 irq_rx high", {31'h0, irq_rx}, 32'h1);
    wr(1'b1, 32'h0001_0001);
    rd(1'b0, d); check("R8 disable drops summaries", d, 32'h0008_0008);
    check("R9 irq_tx low", {31'h0, irq_tx}, 32'h0);
  endtask

  task automatic t_soft();
    logic [31:0] d;
    clear_all();
    wr(1'b1, 32'hFFFF_FFFF);
    pulse(32'h0002_0002);
    @(negedge clk);
    check("R9 both high before soft", {30'h0, irq_tx, irq_rx}, 32'h3);
    @(negedge clk) begin soft_rst = 1'b1; evt_set = 32'h0000_0010; end
    @(negedge clk) begin soft_rst = 1'b0; evt_set = '0; end
    check("R10 irqs cleared", {30'h0, irq_tx, irq_rx}, 32'h0);
    rd(1'b0, d); check("R10 status cleared", d, 32'h0);
    rd(1'b1, d); check("R10 enable cleared", d, 32'h0);
  endtask

  task automatic t_read();
    logic [31:0] d;
    wr(1'b1, 32'hA5A5_5A5A);
    rd(1'b1, d); check("R11 enable readback", d, 32'hA5A5_5A5A);
    rd(1'b0, d); check("R11 status select", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_sticky();
    t_w1c();
    t_set_wins();
    t_tx_summary();
    t_rx_summary();
    t_summary_self();
    t_enable_recompute();
    t_soft();
    t_read();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule